// File: doc/BRIEF.md
# Triggered Capture Memory with Programmable Trigger Position

This block keeps a rolling history of sample words in a circular memory. Once it is armed, it writes a sample either on every clock or only on cycles that the qualify strobe marks. The first trigger it accepts fixes a point in that history. After the trigger the block stores a programmed number of further samples and then stops. The trigger therefore sits at a chosen fraction of the memory: some history comes before it and some comes after.

The trigger position is programmed in 512ths of the depth. On completion the block raises a done flag and freezes its write address. It reports the trigger address, the frozen write address, a wrapped flag and the address of the oldest valid entry, so that an unloader can walk the memory through a registered read port. Three commands control capture. A continuous arm re-arms by itself when the unloader signals that readout is finished. A single-shot arm returns to idle at that point. A stop command disarms at once.

Top module: `trace_capture`

## Requirements
- R1: After reset, `done`, `armed` and `wrapped` are 0, and `wr_addr` is 0.
- R2: A start or single command clears the write address and the wrapped flag and arms capture. With `cfg_qual_only`=0, every clock while armed writes `smp_data` at `wr_addr`, and the address then advances by one.
- R3: With `cfg_qual_only`=1, only cycles with `smp_qual`=1 store a sample and advance `wr_addr`.
- R4: The trigger cycle counts as the first post-trigger store if that cycle stores. Capture ends after exactly DEPTH*(512-P)/512 post-trigger stores, where P is `cfg_pos`. At that point `done` rises and `armed` falls. A `cfg_pos` of 0 acts as 1.
- R5: `trig_addr` holds the value of `wr_addr` in the cycle the trigger was accepted.
- R6: A trigger is ignored when capture is not armed, and any trigger after the first accepted one is ignored until the next arm.
- R7: While `done` is 1, no sample is stored and `wr_addr` holds its value.
- R8: `cmd_stop` has priority over the arm commands. It disarms capture with no further stores and does not raise `done`.
- R9: `wrapped` becomes 1 when a store advances `wr_addr` from DEPTH-1 to 0. `oldest_addr` equals `wr_addr` when `wrapped`=1 and 0 otherwise.
- R10: After a start-armed capture completes, an `unload_done` pulse re-arms capture with the address cleared. After a single-armed capture completes, the same pulse returns the block to idle (`armed`=0, `done`=0).
- R11: `rd_data` presents the word stored at `rd_addr` one clock after `rd_addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data | input | DATA_W | Sample word |
| smp_qual | input | 1 | Marks a qualified sample cycle |
| trig_in | input | 1 | Trigger event |
| cmd_start | input | 1 | Arm, re-arm after each unload |
| cmd_single | input | 1 | Arm for one capture |
| cmd_stop | input | 1 | Disarm immediately |
| unload_done | input | 1 | Readout of a finished capture is complete |
| cfg_qual_only | input | 1 | 1: store qualified cycles only |
| cfg_pos | input | 9 | Trigger position in 512ths of the depth |
| rd_addr | input | AW | Read address |
| rd_data | output | DATA_W | Read data, one cycle latency |
| armed | output | 1 | Capture in progress |
| done | output | 1 | Capture complete |
| wrapped | output | 1 | Memory has wrapped since arming |
| wr_addr | output | AW | Current (frozen when done) write address |
| trig_addr | output | AW | Address of the trigger sample |
| oldest_addr | output | AW | First address to unload |

## Verification
A miscounted post-trigger counter shows up directly at the ports. `done` rises a few stores early or late, so the frozen `wr_addr` differs from trigger address plus post-count, and this is visible in the cycle after the final store. A write pointer that drifts or stores while frozen changes `wr_addr`, `oldest_addr` and the words read back at the trigger address, next to it and at the oldest entry. A trigger latch that was re-opened moves `trig_addr` at the next stray trigger.

// File: rtl/trace_pkg.sv
package trace_pkg;
   localparam int POS_W = 9;
   localparam int FRAC  = 512;

   typedef enum logic [1:0] {
      TS_IDLE  = 2'd0,
      TS_ARMED = 2'd1,
      TS_POST  = 2'd2,
      TS_DONE  = 2'd3
   } trc_state_e;
endpackage

// File: rtl/trace_pos_calc.sv
module trace_pos_calc #(
   parameter int DEPTH = 512,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic [trace_pkg::POS_W-1:0] pos,
   output logic [CW-1:0]               post_n
);
   localparam int SHIFT = AW - trace_pkg::POS_W;

   logic [trace_pkg::POS_W-1:0] pos_eff;
   logic [CW-1:0]               remain;

   always_comb begin
      pos_eff = (pos == '0) ? trace_pkg::POS_W'(1) : pos;
      remain  = CW'(trace_pkg::FRAC) - CW'(pos_eff);
      post_n  = remain << SHIFT;
   end

   always_comb begin
      assert_post_range_R4: assert (post_n >= CW'(DEPTH / trace_pkg::FRAC) && post_n < CW'(DEPTH))
         else $error("post-trigger count out of range");
   end
endmodule

// File: rtl/trace_ram.sv
module trace_ram #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 512,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl #(
   parameter int DEPTH   = 512,
   parameter bit QUAL_EN = 1'b1,
   localparam int AW     = $clog2(DEPTH),
   localparam int CW     = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_qual,
   input  logic          trig_in,
   input  logic          cmd_start,
   input  logic          cmd_single,
   input  logic          cmd_stop,
   input  logic          unload_done,
   input  logic          cfg_qual_only,
   input  logic [CW-1:0] post_n,
   output logic          we,
   output logic [AW-1:0] wptr,
   output logic [AW-1:0] trig_addr,
   output logic          wrapped,
   output logic          armed,
   output logic          done
);
   import trace_pkg::*;

   trc_state_e st;
   logic       mode_cont;
   logic [CW-1:0] postcnt;
   logic       qual_ok, capturing, any_cmd, store;

   generate
      if (QUAL_EN) begin : g_qual
         assign qual_ok = !cfg_qual_only || smp_qual;
      end else begin : g_noqual
         logic unused_qual;
         assign unused_qual = cfg_qual_only ^ smp_qual;
         assign qual_ok = 1'b1;
      end
   endgenerate

   assign capturing = (st == TS_ARMED) || (st == TS_POST);
   assign any_cmd   = cmd_start || cmd_single || cmd_stop;
   assign store     = capturing && qual_ok && !any_cmd;
   assign we        = store;
   assign armed     = capturing;
   assign done      = (st == TS_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= TS_IDLE;
         mode_cont <= 1'b0;
         wptr      <= '0;
         trig_addr <= '0;
         wrapped   <= 1'b0;
         postcnt   <= '0;
      end else if (cmd_stop) begin
         st <= TS_IDLE;
      end else if (cmd_single || cmd_start) begin
         st        <= TS_ARMED;
         mode_cont <= !cmd_single;
         wptr      <= '0;
         wrapped   <= 1'b0;
         postcnt   <= '0;
      end else begin
         if (store) begin
            wptr <= wptr + 1'b1;
            if (wptr == AW'(DEPTH - 1)) wrapped <= 1'b1;
         end
         case (st)
            TS_ARMED: begin
               if (trig_in) begin
                  trig_addr <= wptr;
                  if (store && post_n == CW'(1)) begin
                     st <= TS_DONE;
                  end else begin
                     st      <= TS_POST;
                     postcnt <= store ? post_n - 1'b1 : post_n;
                  end
               end
            end
            TS_POST: begin
               if (store) begin
                  postcnt <= postcnt - 1'b1;
                  if (postcnt == CW'(1)) st <= TS_DONE;
               end
            end
            TS_DONE: begin
               if (unload_done) begin
                  if (mode_cont) begin
                     st      <= TS_ARMED;
                     wptr    <= '0;
                     wrapped <= 1'b0;
                  end else begin
                     st <= TS_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assert_post_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TS_POST) |-> (postcnt != '0));
   assert_frozen_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TS_DONE && !any_cmd && !unload_done) |=> $stable(wptr));
   assert_trig_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TS_POST && !any_cmd) |=> $stable(trig_addr));
   assert_stop_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stop |=> (!armed && !done));
   assert_no_store_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TS_IDLE && !any_cmd) |=> $stable(wptr));
endmodule

// File: rtl/trace_capture.sv
module trace_capture #(
   parameter int DATA_W  = 16,
   parameter int DEPTH   = 512,
   parameter bit QUAL_EN = 1'b1,
   localparam int AW     = $clog2(DEPTH),
   localparam int CW     = AW + 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [DATA_W-1:0]           smp_data,
   input  logic                        smp_qual,
   input  logic                        trig_in,
   input  logic                        cmd_start,
   input  logic                        cmd_single,
   input  logic                        cmd_stop,
   input  logic                        unload_done,
   input  logic                        cfg_qual_only,
   input  logic [trace_pkg::POS_W-1:0] cfg_pos,
   input  logic [AW-1:0]               rd_addr,
   output logic [DATA_W-1:0]           rd_data,
   output logic                        armed,
   output logic                        done,
   output logic                        wrapped,
   output logic [AW-1:0]               wr_addr,
   output logic [AW-1:0]               trig_addr,
   output logic [AW-1:0]               oldest_addr
);
   generate
      if (DEPTH < 512 || DEPTH > 131072 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two from 512 to 131072");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
   endgenerate

   logic [CW-1:0] post_n;
   logic          we;

   trace_pos_calc #(.DEPTH(DEPTH)) u_pos (
      .pos    (cfg_pos),
      .post_n (post_n)
   );

   trace_ctrl #(.DEPTH(DEPTH), .QUAL_EN(QUAL_EN)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .smp_qual      (smp_qual),
      .trig_in       (trig_in),
      .cmd_start     (cmd_start),
      .cmd_single    (cmd_single),
      .cmd_stop      (cmd_stop),
      .unload_done   (unload_done),
      .cfg_qual_only (cfg_qual_only),
      .post_n        (post_n),
      .we            (we),
      .wptr          (wr_addr),
      .trig_addr     (trig_addr),
      .wrapped       (wrapped),
      .armed         (armed),
      .done          (done)
   );

   trace_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
      .clk   (clk),
      .we    (we),
      .waddr (wr_addr),
      .wdata (smp_data),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   assign oldest_addr = wrapped ? wr_addr : '0;

   assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wr_addr == AW'(DEPTH - 1) && !cmd_start && !cmd_single && !cmd_stop) |=> wrapped);
   assert_done_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && armed));
endmodule

// File: tb/tb_trace_capture.sv
module tb_trace_capture;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int DEPTH = 512;
   localparam int AW = 9;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [DW-1:0] smp_data = '0;
   logic smp_qual = 0, trig_in = 0, cmd_start = 0, cmd_single = 0, cmd_stop = 0;
   logic unload_done = 0, cfg_qual_only = 0;
   logic [8:0] cfg_pos = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic armed, done, wrapped;
   logic [AW-1:0] wr_addr, trig_addr, oldest_addr;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   trace_capture #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_qual(smp_qual),
      .trig_in(trig_in), .cmd_start(cmd_start), .cmd_single(cmd_single),
      .cmd_stop(cmd_stop), .unload_done(unload_done), .cfg_qual_only(cfg_qual_only),
      .cfg_pos(cfg_pos), .rd_addr(rd_addr), .rd_data(rd_data), .armed(armed),
      .done(done), .wrapped(wrapped), .wr_addr(wr_addr), .trig_addr(trig_addr),
      .oldest_addr(oldest_addr)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic arm(input bit single);
      @(negedge clk);
      cmd_single = single;
      cmd_start  = !single;
      @(negedge clk);
      cmd_single = 0;
      cmd_start  = 0;
   endtask

   // drives samples from the current negedge; returns samples driven until done
   task automatic feed(input int t1, input int t2, input bit qmode, input int limit,
                       output int cnt);
      cnt = 0;
      for (int i = 0; i < limit; i++) begin
         smp_data = DW'(i);
         smp_qual = qmode ? i[0] : 1'b1;
         trig_in  = (i == t1) || (i == t2);
         cnt++;
         @(negedge clk);
         if (done) break;
      end
      trig_in  = 0;
      smp_qual = 0;
   endtask

   task automatic rd(input int a, output int v);
      rd_addr = AW'(a);
      @(negedge clk);
      v = int'(rd_data);
   endtask

   task automatic t_reset;
      chk("R1", "done", int'(done), 0);
      chk("R1", "armed", int'(armed), 0);
      chk("R1", "wrapped", int'(wrapped), 0);
      chk("R1", "wr_addr", int'(wr_addr), 0);
   endtask

   task automatic t_every_clock;
      int cnt, v;
      cfg_qual_only = 0;
      cfg_pos = 9'd256;
      arm(1);
      feed(600, -1, 0, 2000, cnt);
      chk("R4", "samples until done", cnt, 856);
      chk("R4", "done", int'(done), 1);
      chk("R4", "armed after done", int'(armed), 0);
      chk("R5", "trig_addr", int'(trig_addr), 88);
      chk("R2", "wr_addr", int'(wr_addr), 344);
      chk("R9", "wrapped", int'(wrapped), 1);
      chk("R9", "oldest_addr", int'(oldest_addr), 344);
      rd(88, v);  chk("R11", "word at trigger", v, 600);
      rd(343, v); chk("R2", "newest word", v, 855);
      rd(344, v); chk("R2", "oldest word", v, 344);
      rd(87, v);  chk("R2", "word before trigger", v, 599);
   endtask

   task automatic t_frozen;
      int v;
      for (int k = 0; k < 4; k++) begin
         smp_data = 16'hBEEF;
         trig_in  = 1;
         @(negedge clk);
      end
      trig_in = 0;
      chk("R7", "wr_addr frozen", int'(wr_addr), 344);
      chk("R7", "done held", int'(done), 1);
      rd(344, v); chk("R7", "no store while done", v, 344);
      @(negedge clk); unload_done = 1;
      @(negedge clk); unload_done = 0;
      chk("R10", "single unload idle armed", int'(armed), 0);
      chk("R10", "single unload idle done", int'(done), 0);
   endtask

   task automatic t_qualified;
      int cnt, v;
      cfg_qual_only = 1;
      cfg_pos = 9'd511;
      arm(1);
      feed(41, -1, 1, 2000, cnt);
      chk("R3", "samples until done", cnt, 42);
      chk("R3", "trig_addr", int'(trig_addr), 20);
      chk("R3", "wr_addr", int'(wr_addr), 21);
      chk("R9", "not wrapped", int'(wrapped), 0);
      chk("R9", "oldest_addr", int'(oldest_addr), 0);
      rd(20, v); chk("R3", "word at trigger", v, 41);
      rd(19, v); chk("R3", "previous qualified word", v, 39);
      rd(0, v);  chk("R3", "first qualified word", v, 1);
      cfg_qual_only = 0;
   endtask

   task automatic t_ignored_trig;
      int cnt;
      @(negedge clk); unload_done = 1;
      @(negedge clk); unload_done = 0;
      @(negedge clk); trig_in = 1;
      @(negedge clk); trig_in = 0;
      @(negedge clk);
      chk("R6", "idle trigger no done", int'(done), 0);
      chk("R6", "idle trigger not armed", int'(armed), 0);
      cfg_pos = 9'd1;
      arm(1);
      feed(10, 20, 0, 2000, cnt);
      chk("R6", "samples until done", cnt, 521);
      chk("R6", "trig_addr keeps first", int'(trig_addr), 10);
      chk("R4", "wr_addr", int'(wr_addr), 9);
      chk("R9", "wrapped", int'(wrapped), 1);
   endtask

   task automatic t_stop;
      int cnt;
      cfg_pos = 9'd256;
      arm(1);
      feed(-1, -1, 0, 5, cnt);
      chk("R2", "wr_addr after 5", int'(wr_addr), 5);
      cmd_stop = 1; cmd_start = 1;
      @(negedge clk);
      cmd_stop = 0; cmd_start = 0;
      feed(0, -1, 0, 5, cnt);
      chk("R8", "armed", int'(armed), 0);
      chk("R8", "done", int'(done), 0);
      chk("R8", "wr_addr unchanged", int'(wr_addr), 5);
   endtask

   task automatic t_continuous;
      int cnt;
      cfg_pos = 9'd511;
      arm(0);
      feed(3, -1, 0, 100, cnt);
      chk("R4", "cont samples", cnt, 4);
      chk("R4", "cont wr_addr", int'(wr_addr), 4);
      unload_done = 1;
      @(negedge clk);
      unload_done = 0;
      chk("R10", "re-armed", int'(armed), 1);
      chk("R10", "done cleared", int'(done), 0);
      chk("R10", "address cleared", int'(wr_addr), 0);
      feed(0, -1, 0, 100, cnt);
      chk("R10", "second capture samples", cnt, 1);
      chk("R10", "second capture done", int'(done), 1);
      unload_done = 1;
      @(negedge clk);
      unload_done = 0;
      chk("R10", "re-armed again", int'(armed), 1);
      cmd_stop = 1;
      @(negedge clk);
      cmd_stop = 0;
   endtask

   task automatic t_pos_zero;
      int cnt;
      cfg_pos = 9'd0;
      arm(1);
      feed(0, -1, 0, 2000, cnt);
      chk("R4", "pos 0 as 1 samples", cnt, 511);
      chk("R4", "pos 0 wr_addr", int'(wr_addr), 511);
      chk("R9", "pos 0 not wrapped", int'(wrapped), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_every_clock();
      t_frozen();
      t_qualified();
      t_ignored_trig();
      t_stop();
      t_continuous();
      t_pos_zero();
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule